// File: doc/BRIEF.md
# Byte-Wide Host Register Port with Strobe Handshake

This block is the slave side of an 8-bit parallel host bus. The bus has an active-low chip select, an active-low data strobe and a read/write select line. The host first sets a 2-bit register index and the direction. It then pulls both strobes low to open a bus cycle and releases them to close it. Every pin is brought into the core clock domain through two-flop synchronisers, so the host has to hold each phase for several core clocks.

Writes to any of the four registers go to the core side as a one-cycle beat that carries the register index and the byte. In the other direction, the core pushes message bytes into a small queue. The host reads them one at a time through the message register. A status bit and an active-low interrupt line show whether a message is waiting. The core can raise a message at any time without a prior host request.

Top module: `par_host_port`

## Requirements
- R1: After reset, `nirq` is high, `hdata_oe` is low, `wr_valid` is low and `msg_ready` is high.
- R2: A bus cycle starts when both `hcs_n` and `hds_n` are low and ends when they go back high. A write cycle (`hrw`=0) produces `wr_valid` once the cycle has ended, with `wr_idx` equal to the register index and `wr_byte` equal to the byte driven during the cycle.
- R3: Each write cycle gives exactly one `wr_valid` pulse, one clock wide. Read cycles give none.
- R4: `hdata_oe` is high only while `hcs_n`=0, `hds_n`=0 and `hrw`=1.
- R5: `nirq` is low exactly when at least one outgoing message byte is queued. Host reads of registers other than index 0 do not change it.
- R6: A read of index 1 (status) returns 0x01 when a message is pending and 0x00 otherwise.
- R7: A read of index 0 returns the oldest queued byte and removes it when the cycle ends. Bytes come out in the order they were pushed.
- R8: A read of index 0 with an empty queue returns 0x00 and changes nothing.
- R9: Reads of index 2 and index 3 return 0x00.
- R10: `msg_ready` is low when `QDEPTH` bytes are queued. A `msg_valid` beat seen while it is low is dropped.
- R11: `hds_n` low while `hcs_n` stays high is not a bus cycle. It produces no `wr_valid` and no dequeue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hcs_n | input | 1 | Host chip select, active low |
| hds_n | input | 1 | Host data strobe, active low |
| hrw | input | 1 | 1 = read, 0 = write |
| hadr | input | 2 | Register index: 0 message, 1 status/control, 2 PCM port, 3 compressed port |
| hdata_in | input | 8 | Byte driven by the host |
| hdata_out | output | 8 | Byte returned to the host |
| hdata_oe | output | 1 | Output enable for the data pins |
| nirq | output | 1 | Interrupt request, low while a message is pending |
| wr_valid | output | 1 | One-cycle beat for a completed host write |
| wr_idx | output | 2 | Register index of the write |
| wr_byte | output | 8 | Data byte of the write |
| msg_valid | input | 1 | Core pushes an outgoing message byte |
| msg_byte | input | 8 | Outgoing message byte |
| msg_ready | output | 1 | Queue has room |

## Verification
The assertions assume that the core pushes a message byte only while the queue has room, or that such a push is dropped, and that the queue holds at least two entries. They also assume that a dequeue can only happen once a host cycle has ended. The stimulus holds the index, the direction and the data stable for several clocks before the strobes fall, keeps them stable until the strobes have been released for several clocks, and pushes message bytes only between host cycles. Random sequences of writes, reads and pushes are mixed with directed cases: reading an empty queue, filling the queue, and a data-strobe pulse without chip select.

// File: rtl/par_host_port.sv
module par_host_port #(
  parameter int DW     = 8,
  parameter int AW     = 2,
  parameter int QDEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hcs_n,
  input  logic          hds_n,
  input  logic          hrw,
  input  logic [AW-1:0] hadr,
  input  logic [DW-1:0] hdata_in,
  output logic [DW-1:0] hdata_out,
  output logic          hdata_oe,
  output logic          nirq,
  output logic          wr_valid,
  output logic [AW-1:0] wr_idx,
  output logic [DW-1:0] wr_byte,
  input  logic          msg_valid,
  input  logic [DW-1:0] msg_byte,
  output logic          msg_ready
);
  localparam int QAW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CW  = $clog2(QDEPTH + 1);
  localparam logic [QAW-1:0] QLAST = QAW'(QDEPTH - 1);
  localparam logic [CW-1:0]  QFULL = CW'(QDEPTH);

  logic [1:0]    cs_sy, ds_sy, rw_sy;
  logic [AW-1:0] a_sy0, a_sy1;
  logic [DW-1:0] d_sy0, d_sy1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy <= 2'b11;
      ds_sy <= 2'b11;
      rw_sy <= 2'b11;
      a_sy0 <= '0;
      a_sy1 <= '0;
      d_sy0 <= '0;
      d_sy1 <= '0;
    end else begin
      cs_sy <= {cs_sy[0], hcs_n};
      ds_sy <= {ds_sy[0], hds_n};
      rw_sy <= {rw_sy[0], hrw};
      a_sy0 <= hadr;
      a_sy1 <= a_sy0;
      d_sy0 <= hdata_in;
      d_sy1 <= d_sy0;
    end
  end

  logic active, act_q, start, fin;
  logic          cyc_rw;
  logic [AW-1:0] cyc_adr;
  logic [DW-1:0] wlat;

  assign active = ~cs_sy[1] & ~ds_sy[1];
  assign start  = active & ~act_q;
  assign fin    = ~active & act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      cyc_rw  <= 1'b1;
      cyc_adr <= '0;
      wlat    <= '0;
    end else begin
      act_q <= active;
      if (start) begin
        cyc_rw  <= rw_sy[1];
        cyc_adr <= a_sy1;
      end
      if (active) wlat <= d_sy1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_idx   <= '0;
      wr_byte  <= '0;
    end else begin
      wr_valid <= fin & ~cyc_rw;
      if (fin & ~cyc_rw) begin
        wr_idx  <= cyc_adr;
        wr_byte <= wlat;
      end
    end
  end

  logic [DW-1:0]  q_mem [QDEPTH];
  logic [QAW-1:0] wp, rp;
  logic [CW-1:0]  cnt;
  logic push, pop, pending;

  assign pending   = (cnt != '0);
  assign msg_ready = (cnt != QFULL);
  assign push      = msg_valid & msg_ready;
  assign pop       = fin & cyc_rw & (cyc_adr == '0) & pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == QLAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == QLAST) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) q_mem[wp] <= msg_byte;
  end

  always_comb begin
    case (a_sy1)
      AW'(0):  hdata_out = pending ? q_mem[rp] : '0;
      AW'(1):  hdata_out = DW'(pending);
      default: hdata_out = '0;
    endcase
  end

  assign hdata_oe = ~hcs_n & ~hds_n & hrw;
  assign nirq     = ~pending;
endmodule

module par_host_port_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic nirq,
  input logic msg_ready,
  input logic msg_valid
);
  // R3
  wr_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  // R10
  full_implies_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_ready |-> !nirq);
  // R5
  irq_needs_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nirq) |-> $past(msg_valid));
  // R7
  irq_clear_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nirq) |-> $past(!msg_valid));
endmodule

bind par_host_port par_host_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .nirq(nirq),
  .msg_ready(msg_ready), .msg_valid(msg_valid)
);

// File: tb/par_host_port_bench.sv
`timescale 1ns/1ps
module par_host_port_bench;
  localparam int QD = 4;
  logic clk = 0, rst_n = 0;
  logic hcs_n = 1, hds_n = 1, hrw = 1;
  logic [1:0] hadr = 0;
  logic [7:0] hdata_in = 0, hdata_out, wr_byte, msg_byte = 0;
  logic hdata_oe, nirq, wr_valid, msg_valid = 0, msg_ready;
  logic [1:0] wr_idx;

  par_host_port #(.QDEPTH(QD)) u_par_host_port (
    .clk(clk), .rst_n(rst_n), .hcs_n(hcs_n), .hds_n(hds_n), .hrw(hrw),
    .hadr(hadr), .hdata_in(hdata_in), .hdata_out(hdata_out), .hdata_oe(hdata_oe),
    .nirq(nirq), .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_byte(wr_byte),
    .msg_valid(msg_valid), .msg_byte(msg_byte), .msg_ready(msg_ready));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] mq [$];
  int unsigned seed = 32'h1234;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(logic [1:0] a);
    if (a == 2'd0) return (mq.size() != 0) ? mq[0] : 8'h00;
    if (a == 2'd1) return (mq.size() != 0) ? 8'h01 : 8'h00;
    return 8'h00;
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic host_write(logic [1:0] a, logic [7:0] d);
    int pulses = 0;
    logic [1:0] gi = 0;
    logic [7:0] gb = 0;
    @(negedge clk); hadr = a; hrw = 0; hdata_in = d;
    idle(3);
    hcs_n = 0; hds_n = 0;
    idle(5);
    chk("R4 oe low on write", hdata_oe, 0);
    hcs_n = 1; hds_n = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (wr_valid) begin pulses++; gi = wr_idx; gb = wr_byte; end
    end
    chk("R3 one pulse per write", pulses, 1);
    chk("R2 write index", gi, a);
    chk("R2 write byte", gb, d);
  endtask

  task automatic host_read(logic [1:0] a);
    logic [7:0] e;
    int pulses = 0;
    @(negedge clk); hadr = a; hrw = 1;
    idle(3);
    e = exp_read(a);
    chk("R4 oe low before strobes", hdata_oe, 0);
    hcs_n = 0; hds_n = 0;
    idle(5);
    chk("R4 oe high in read", hdata_oe, 1);
    if (a == 0) chk(mq.size() ? "R7 message read" : "R8 empty read", hdata_out, e);
    else if (a == 1) chk("R6 status read", hdata_out, e);
    else chk("R9 data port read", hdata_out, e);
    hcs_n = 1; hds_n = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (wr_valid) pulses++;
    end
    chk("R3 no pulse on read", pulses, 0);
    if (a == 0 && mq.size() != 0) void'(mq.pop_front());
    chk("R5 irq after read", nirq, mq.size() == 0);
  endtask

  task automatic push(logic [7:0] b);
    @(negedge clk);
    chk("R10 ready", msg_ready, mq.size() < QD);
    msg_valid = 1; msg_byte = b;
    if (mq.size() < QD) mq.push_back(b);
    @(negedge clk); msg_valid = 0;
    @(negedge clk);
    chk("R5 irq after push", nirq, mq.size() == 0);
  endtask

  bit done = 0;
  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int p0;
    idle(3);
    chk("R1 nirq", nirq, 1);
    chk("R1 oe", hdata_oe, 0);
    chk("R1 wr_valid", wr_valid, 0);
    chk("R1 msg_ready", msg_ready, 1);
    rst_n = 1;
    idle(3);
    host_read(2'd0);
    host_read(2'd1);
    host_write(2'd2, 8'hA5);
    for (int i = 0; i < QD + 2; i++) push(8'h10 + 8'(i));
    chk("R10 full", msg_ready, 0);
    host_read(2'd1);
    host_read(2'd3);
    host_read(2'd2);
    for (int i = 0; i < QD + 1; i++) host_read(2'd0);
    @(negedge clk); hadr = 0; hrw = 0; hdata_in = 8'h5A;
    push(8'h77);
    idle(2);
    p0 = 0;
    hds_n = 0; idle(6); hds_n = 1;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (wr_valid) p0++; end
    chk("R11 no pulse w/o cs", p0, 0);
    chk("R11 no dequeue w/o cs", nirq, 0);
    host_read(2'd0);
    for (int k = 0; k < 300; k++) begin
      int op = $urandom(seed) % 4;
      seed = seed + 1;
      case (op)
        0: host_write(2'($urandom % 4), 8'($urandom));
        1: host_read(2'($urandom % 4));
        2: host_read(2'd0);
        default: push(8'($urandom));
      endcase
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule